// File: doc/BRIEF.md
# Module Management Register Space

This block holds the byte-wide register space that sits behind the management bus of a pluggable optical transceiver. The block does not decode the bits on the wire. A separate bus front end does that work and passes requests to this block one at a time, at transaction level. A START request carries a 7-bit device select and a byte address. Each WRITE request carries one data byte. Each READ request asks for one byte back. One pointer is shared by all request types and gains one after every byte that is written or read.

Two device selects are decoded:
- The identification page holds programmable identity bytes and two checksum bytes. Each checksum is formed live from the bytes it covers.
- The diagnostics page holds alarm/warning threshold bytes, a checksum byte that tracks them, and a status/control byte. In that byte, three bits mirror the module pins and one bit is a software laser-off control. The page also has a 128-byte user area in its upper half. That area is locked until a password is written: every byte of a four-byte window must hold 11h.

Requests travel on a valid/ready channel, and read bytes return on a valid/ready channel. The request channel is stalled only while a read byte is waiting and the consumer is not ready to take it. A response byte does not change while it waits. The pin mirrors and the laser-off output are plain levels with no handshake.

Top module: `mgmt_regmap`

## Requirements
- R1: A START with device select 1010000 (50h) selects the identification page, and one with 1010001 (51h) selects the diagnostics page. After a START with any other select, writes are dropped and reads return FFh.
- R2: START loads the pointer with its byte address. Each accepted WRITE or READ advances the pointer by one, and 255 wraps to 0. This holds whether a device is selected or not.
- R3: A READ accepted on a clock edge presents its byte with rsp_valid high after that edge. While rsp_valid is high and rsp_ready is low, req_ready is low, and rsp_data and rsp_valid hold their values.
- R4: Identification-page bytes 0 to 127, except 63 and 95, store written bytes and read them back. Bytes 128 to 255 read 00h, and writes to them are dropped.
- R5: Identification-page byte 63 reads the low 8 bits of the sum of bytes 0 to 62. Byte 95 reads the low 8 bits of the sum of bytes 64 to 94. Writes to bytes 63 and 95 are dropped.
- R6: Diagnostics-page bytes 0 to 94 are read/write. Byte 95 reads the low 8 bits of the sum of bytes 0 to 94 and follows every write to them.
- R7: Diagnostics byte 110 reads with these bits:
  - bit 7: the tx-disable pin
  - bit 6: a stored software disable, which also drives soft_tx_off
  - bit 2: the tx-fault pin
  - bit 1: the loss-of-signal pin
  - all other bits: 0

  A write to byte 110 changes only bit 6.
- R8: Diagnostics bytes 96 to 109 and 111 to 122 read 00h, and writes to them are dropped. Bytes 123 to 127 are read/write.
- R9: When diagnostics bytes 123, 124, 125 and 126 all hold 11h, diagnostics bytes 128 to 255 are read/write.
- R10: When any of bytes 123 to 126 differs from 11h, diagnostics bytes 128 to 255 read 00h and writes to them are dropped. The stored contents are kept and appear again when the password is restored.
- R11: After reset, these hold:
  - rsp_valid is 0 and soft_tx_off is 0.
  - No device is selected.
  - The pointer is 0.
  - All stored bytes are 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_op | input | 2 | 0 START, 1 WRITE, 2 READ, 3 no operation |
| req_dev | input | 7 | Device select for START |
| req_addr | input | 8 | Byte address for START |
| req_wdata | input | 8 | Data byte for WRITE |
| rsp_valid | output | 1 | Read byte present |
| rsp_ready | input | 1 | Consumer takes the read byte |
| rsp_data | output | 8 | Read byte |
| pin_tx_disable | input | 1 | Level of the tx-disable pin |
| pin_tx_fault | input | 1 | Level of the tx-fault output |
| pin_rx_los | input | 1 | Level of the loss-of-signal output |
| soft_tx_off | output | 1 | Software laser-off control |

## Verification
The bench builds the block with its default parameters: device selects 50h and 51h, and a password byte of 11h. With these values the bench reaches the following cases:
- both checksum paths, checked across full-page writes
- the 255-to-0 pointer wrap on the diagnostics page
- an unlock, relock and restore sequence, to show that user bytes are kept while hidden
- a start to an unknown device

With rsp_ready held low, the bench also stalls a read against a second pending request.

// File: rtl/regmap_pkg.sv
package regmap_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;
  localparam int HALF_BYTES = 1 << (ADDR_W - 1);

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_NOP   = 2'd3
  } req_op_e;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_ID   = 2'd1,
    SEL_DIAG = 2'd2
  } page_sel_e;

  // identification-page checksum spans
  localparam int ID_CHK_A_ADDR = 63;
  localparam int ID_CHK_B_ADDR = 95;
  localparam int ID_CHK_B_FIRST = 64;

  // diagnostics-page layout
  localparam int DG_THR_LAST   = 94;
  localparam int DG_CHK_ADDR   = 95;
  localparam int DG_STAT_ADDR  = 110;
  localparam int DG_PW_FIRST   = 123;
  localparam int DG_PW_LEN     = 4;
  localparam int DG_SPARE_ADDR = 127;
endpackage

// File: rtl/regmap_port.sv
module regmap_port
  import regmap_pkg::*;
#(
  parameter logic [6:0] ID_DEV   = 7'h50,
  parameter logic [6:0] DIAG_DEV = 7'h51
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [6:0]        req_dev,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic [ADDR_W-1:0] ptr,
  output logic              wr_id,
  output logic              wr_diag,
  output logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-1:0] id_rd,
  input  logic [DATA_W-1:0] diag_rd
);
  page_sel_e sel_q;
  logic      accept;
  logic      is_wr, is_rd, is_start;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign is_start  = accept && (req_op == OP_START);
  assign is_wr     = accept && (req_op == OP_WRITE);
  assign is_rd     = accept && (req_op == OP_READ);

  assign wr_id   = is_wr && (sel_q == SEL_ID);
  assign wr_diag = is_wr && (sel_q == SEL_DIAG);
  assign wr_data = req_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= SEL_NONE;
      ptr   <= '0;
    end else if (is_start) begin
      ptr <= req_addr;
      if (req_dev == ID_DEV)        sel_q <= SEL_ID;
      else if (req_dev == DIAG_DEV) sel_q <= SEL_DIAG;
      else                          sel_q <= SEL_NONE;
    end else if (is_wr || is_rd) begin
      ptr <= ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (is_rd) begin
      rsp_valid <= 1'b1;
      unique case (sel_q)
        SEL_ID:   rsp_data <= id_rd;
        SEL_DIAG: rsp_data <= diag_rd;
        default:  rsp_data <= '1;
      endcase
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assert_rsp_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  assert_ptr_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((is_wr || is_rd) && ptr == '1) |=> (ptr == '0));
endmodule

// File: rtl/regmap_id_page.sv
module regmap_id_page
  import regmap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem [HALF_BYTES];
  logic [DATA_W-1:0] chk_a, chk_b;
  logic              chk_slot;

  assign chk_slot = (addr == ADDR_W'(ID_CHK_A_ADDR)) || (addr == ADDR_W'(ID_CHK_B_ADDR));

  always_comb begin
    chk_a = '0;
    for (int i = 0; i < ID_CHK_A_ADDR; i++) chk_a = chk_a + mem[i];
    chk_b = '0;
    for (int i = ID_CHK_B_FIRST; i < ID_CHK_B_ADDR; i++) chk_b = chk_b + mem[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < HALF_BYTES; i++) mem[i] <= '0;
    end else if (wr_en && !addr[ADDR_W-1] && !chk_slot) begin
      mem[addr[ADDR_W-2:0]] <= wr_data;
    end
  end

  always_comb begin
    if (addr[ADDR_W-1])                        rd_data = '0;
    else if (addr == ADDR_W'(ID_CHK_A_ADDR))   rd_data = chk_a;
    else if (addr == ADDR_W'(ID_CHK_B_ADDR))   rd_data = chk_b;
    else                                       rd_data = mem[addr[ADDR_W-2:0]];
  end

  assert_chk_write_dropped_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(ID_CHK_A_ADDR)) |=> ($stable(chk_a) && $stable(chk_b)));
endmodule

// File: rtl/regmap_diag_page.sv
module regmap_diag_page
  import regmap_pkg::*;
#(
  parameter logic [DATA_W-1:0] PW_BYTE = 8'h11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              pin_tx_disable,
  input  logic              pin_tx_fault,
  input  logic              pin_rx_los,
  output logic              soft_tx_off
);
  logic [DATA_W-1:0] low_mem  [HALF_BYTES];
  logic [DATA_W-1:0] user_mem [HALF_BYTES];
  logic [DATA_W-1:0] thr_sum;
  logic [DATA_W-1:0] status;
  logic [DG_PW_LEN-1:0] pw_hit;
  logic              unlocked;
  logic              low_rw;

  genvar g;
  generate
    for (g = 0; g < DG_PW_LEN; g++) begin : g_pw
      assign pw_hit[g] = (low_mem[DG_PW_FIRST + g] == PW_BYTE);
    end
  endgenerate
  assign unlocked = &pw_hit;

  assign low_rw = (addr <= ADDR_W'(DG_THR_LAST)) ||
                  ((addr >= ADDR_W'(DG_PW_FIRST)) && (addr <= ADDR_W'(DG_SPARE_ADDR)));

  always_comb begin
    thr_sum = '0;
    for (int i = 0; i <= DG_THR_LAST; i++) thr_sum = thr_sum + low_mem[i];
  end

  assign status = {pin_tx_disable, soft_tx_off, 3'b000, pin_tx_fault, pin_rx_los, 1'b0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < HALF_BYTES; i++) begin
        low_mem[i]  <= '0;
        user_mem[i] <= '0;
      end
      soft_tx_off <= 1'b0;
    end else if (wr_en) begin
      if (addr[ADDR_W-1]) begin
        if (unlocked) user_mem[addr[ADDR_W-2:0]] <= wr_data;
      end else if (addr == ADDR_W'(DG_STAT_ADDR)) begin
        soft_tx_off <= wr_data[6];
      end else if (low_rw) begin
        low_mem[addr[ADDR_W-2:0]] <= wr_data;
      end
    end
  end

  always_comb begin
    if (addr[ADDR_W-1])                      rd_data = unlocked ? user_mem[addr[ADDR_W-2:0]] : '0;
    else if (addr == ADDR_W'(DG_CHK_ADDR))   rd_data = thr_sum;
    else if (addr == ADDR_W'(DG_STAT_ADDR))  rd_data = status;
    else if (low_rw)                         rd_data = low_mem[addr[ADDR_W-2:0]];
    else                                     rd_data = '0;
  end

  assert_locked_write_dropped_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr[ADDR_W-1] && !unlocked) |=>
      (user_mem[$past(addr[ADDR_W-2:0])] == $past(user_mem[addr[ADDR_W-2:0]])));

  assert_soft_off_only_by_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == ADDR_W'(DG_STAT_ADDR)) |=> $stable(soft_tx_off));
endmodule

// File: rtl/mgmt_regmap.sv
module mgmt_regmap
  import regmap_pkg::*;
#(
  parameter logic [6:0] ID_DEV   = 7'h50,
  parameter logic [6:0] DIAG_DEV = 7'h51,
  parameter logic [7:0] PW_BYTE  = 8'h11
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic [1:0] req_op,
  input  logic [6:0] req_dev,
  input  logic [7:0] req_addr,
  input  logic [7:0] req_wdata,
  output logic       rsp_valid,
  input  logic       rsp_ready,
  output logic [7:0] rsp_data,
  input  logic       pin_tx_disable,
  input  logic       pin_tx_fault,
  input  logic       pin_rx_los,
  output logic       soft_tx_off
);
  logic [ADDR_W-1:0] ptr;
  logic              wr_id, wr_diag;
  logic [DATA_W-1:0] wr_data, id_rd, diag_rd;

  regmap_port #(.ID_DEV(ID_DEV), .DIAG_DEV(DIAG_DEV)) port_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_dev(req_dev), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .ptr(ptr), .wr_id(wr_id), .wr_diag(wr_diag), .wr_data(wr_data),
    .id_rd(id_rd), .diag_rd(diag_rd)
  );

  regmap_id_page id_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_id), .addr(ptr),
    .wr_data(wr_data), .rd_data(id_rd)
  );

  regmap_diag_page #(.PW_BYTE(PW_BYTE)) diag_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_diag), .addr(ptr),
    .wr_data(wr_data), .rd_data(diag_rd),
    .pin_tx_disable(pin_tx_disable), .pin_tx_fault(pin_tx_fault),
    .pin_rx_los(pin_rx_los), .soft_tx_off(soft_tx_off)
  );

  assert_stall_blocks_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);
endmodule

// File: tb/mgmt_regmap_tb_top.sv
module mgmt_regmap_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [1:0] req_op = 2'd3;
  logic [6:0] req_dev = '0;
  logic [7:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic       rsp_valid;
  logic       rsp_ready = 1'b1;
  logic [7:0] rsp_data;
  logic       pin_tx_disable = 1'b0;
  logic       pin_tx_fault = 1'b0;
  logic       pin_rx_los = 1'b0;
  logic       soft_tx_off;

  int checks = 0;
  int errors = 0;
  logic [7:0] dg_thr [95];

  always #10 clk = ~clk;

  mgmt_regmap dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_dev(req_dev), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .pin_tx_disable(pin_tx_disable), .pin_tx_fault(pin_tx_fault),
    .pin_rx_los(pin_rx_los), .soft_tx_off(soft_tx_off)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic start(input logic [6:0] dev, input logic [7:0] a);
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'd0; req_dev = dev; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0; req_op = 2'd3;
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'd1; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_op = 2'd3;
  endtask

  task automatic rd(output logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'd2;
    @(negedge clk);
    req_valid = 1'b0; req_op = 2'd3;
    if (rsp_valid !== 1'b1) begin
      checks++; errors++;
      $display("FAIL R3 rsp_valid actual %0b expected 1", rsp_valid);
    end
    d = rsp_data;
  endtask

  function automatic logic [7:0] id_pat(input int i);
    return 8'((i * 7) + 3);
  endfunction

  task automatic t_reset();
    logic [7:0] d;
    chk("R11 rsp_valid", {7'd0, rsp_valid}, 8'd0);
    chk("R11 soft_tx_off", {7'd0, soft_tx_off}, 8'd0);
    chk("R3 req_ready idle", {7'd0, req_ready}, 8'd1);
    rd(d);
    chk("R11 R1 read with no selection", d, 8'hFF);
    start(7'h51, 8'd20);
    rd(d);
    chk("R11 cleared threshold", d, 8'h00);
  endtask

  task automatic t_id_page();
    logic [7:0] d;
    logic [7:0] sa, sb;
    int bad;
    start(7'h50, 8'd0);
    for (int i = 0; i < 128; i++) wr(id_pat(i));
    sa = '0; sb = '0;
    for (int i = 0; i < 63; i++) sa = sa + id_pat(i);
    for (int i = 64; i < 95; i++) sb = sb + id_pat(i);
    start(7'h50, 8'd0);
    bad = 0;
    for (int i = 0; i < 128; i++) begin
      rd(d);
      if (i == 63) chk("R5 checksum byte 63", d, sa);
      else if (i == 95) chk("R5 checksum byte 95", d, sb);
      else if (d !== id_pat(i)) begin
        bad++;
        if (bad == 1) chk("R4 id readback", d, id_pat(i));
      end
    end
    if (bad == 0) chk("R4 id readback", 8'd0, 8'd0);
    start(7'h50, 8'd200);
    wr(8'h5C);
    start(7'h50, 8'd200);
    rd(d);
    chk("R4 id upper write dropped", d, 8'h00);
    bad = 0;
    start(7'h50, 8'd128);
    for (int i = 128; i < 256; i++) begin
      rd(d);
      if (d !== 8'h00) bad++;
    end
    chk("R4 id upper reads zero (count)", 8'(bad), 8'd0);
  endtask

  task automatic t_diag_thr();
    logic [7:0] d, s;
    start(7'h51, 8'd0);
    for (int i = 0; i < 95; i++) begin
      dg_thr[i] = 8'((i * 5) + 1);
      wr(dg_thr[i]);
    end
    wr(8'hEE);
    s = '0;
    for (int i = 0; i < 95; i++) s = s + dg_thr[i];
    start(7'h51, 8'd95);
    rd(d);
    chk("R6 diag checksum", d, s);
    start(7'h51, 8'd10);
    wr(8'h99);
    dg_thr[10] = 8'h99;
    s = '0;
    for (int i = 0; i < 95; i++) s = s + dg_thr[i];
    start(7'h51, 8'd9);
    rd(d);
    chk("R6 threshold readback", d, dg_thr[9]);
    rd(d);
    chk("R6 rewritten threshold", d, 8'h99);
    start(7'h51, 8'd95);
    rd(d);
    chk("R6 checksum tracks write", d, s);
  endtask

  task automatic t_status();
    logic [7:0] d;
    pin_tx_disable = 1'b1; pin_tx_fault = 1'b1; pin_rx_los = 1'b0;
    start(7'h51, 8'd110);
    wr(8'hFF);
    chk("R7 soft_tx_off set", {7'd0, soft_tx_off}, 8'd1);
    start(7'h51, 8'd110);
    rd(d);
    chk("R7 status pins+soft", d, 8'hC4);
    pin_tx_disable = 1'b0; pin_tx_fault = 1'b0; pin_rx_los = 1'b1;
    start(7'h51, 8'd110);
    wr(8'hBF);
    rd(d);
    chk("R7 status after clear", d, 8'h00);
    start(7'h51, 8'd110);
    rd(d);
    chk("R7 status los only", d, 8'h02);
    chk("R7 soft_tx_off clear", {7'd0, soft_tx_off}, 8'd0);
  endtask

  task automatic t_readonly();
    logic [7:0] d;
    start(7'h51, 8'd100);
    wr(8'h3C);
    start(7'h51, 8'd115);
    wr(8'h3C);
    start(7'h51, 8'd100);
    rd(d);
    chk("R8 byte 100 read-only", d, 8'h00);
    start(7'h51, 8'd115);
    rd(d);
    chk("R8 byte 115 read-only", d, 8'h00);
    start(7'h51, 8'd127);
    wr(8'h6A);
    start(7'h51, 8'd127);
    rd(d);
    chk("R8 byte 127 read/write", d, 8'h6A);
  endtask

  task automatic t_password();
    logic [7:0] d;
    start(7'h51, 8'd130);
    wr(8'hAB);
    start(7'h51, 8'd130);
    rd(d);
    chk("R10 locked read", d, 8'h00);
    start(7'h51, 8'd123);
    for (int i = 0; i < 4; i++) wr(8'h11);
    start(7'h51, 8'd130);
    rd(d);
    chk("R10 locked write was dropped", d, 8'h00);
    start(7'h51, 8'd130);
    wr(8'h5A);
    start(7'h51, 8'd130);
    rd(d);
    chk("R9 unlocked readback", d, 8'h5A);
    start(7'h51, 8'd124);
    wr(8'h12);
    start(7'h51, 8'd130);
    rd(d);
    chk("R10 relocked read", d, 8'h00);
    start(7'h51, 8'd130);
    wr(8'h77);
    start(7'h51, 8'd124);
    wr(8'h11);
    start(7'h51, 8'd130);
    rd(d);
    chk("R10 contents kept across relock", d, 8'h5A);
  endtask

  task automatic t_wrap();
    logic [7:0] d, s;
    start(7'h51, 8'd255);
    wr(8'hC3);
    wr(8'h42);
    dg_thr[0] = 8'h42;
    start(7'h51, 8'd255);
    rd(d);
    chk("R2 R9 byte 255", d, 8'hC3);
    rd(d);
    chk("R2 wrap to byte 0", d, 8'h42);
    rd(d);
    chk("R2 continue at byte 1", d, dg_thr[1]);
    s = '0;
    for (int i = 0; i < 95; i++) s = s + dg_thr[i];
    start(7'h51, 8'd95);
    rd(d);
    chk("R6 checksum after wrap write", d, s);
  endtask

  task automatic t_other_dev();
    logic [7:0] d;
    start(7'h52, 8'd5);
    wr(8'h00);
    rd(d);
    chk("R1 unknown device read", d, 8'hFF);
    start(7'h50, 8'd5);
    rd(d);
    chk("R1 id byte untouched", d, id_pat(5));
    start(7'h51, 8'd5);
    rd(d);
    chk("R1 diag byte untouched", d, dg_thr[5]);
  endtask

  task automatic t_backpressure();
    logic [7:0] first;
    start(7'h50, 8'd10);
    rsp_ready = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'd2;
    @(negedge clk);
    chk("R3 response valid", {7'd0, rsp_valid}, 8'd1);
    chk("R3 response data", rsp_data, id_pat(10));
    first = rsp_data;
    chk("R3 req_ready low while stalled", {7'd0, req_ready}, 8'd0);
    @(negedge clk);
    chk("R3 data held", rsp_data, first);
    chk("R3 still stalled", {7'd0, req_ready}, 8'd0);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; req_op = 2'd3;
    chk("R3 second read after release", rsp_data, id_pat(11));
    @(negedge clk);
    chk("R3 response consumed", {7'd0, rsp_valid}, 8'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_id_page();
    t_diag_thr();
    t_status();
    t_readonly();
    t_password();
    t_wrap();
    t_other_dev();
    t_backpressure();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual running expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule